// File: doc/BRIEF.md
# Fault Protection Retry Supervisor

This block decides how an output rail reacts once its fault detectors have reported. It takes four already-qualified fault flags (undervoltage, overvoltage, overcurrent, thermal shutdown) and an indication that overcurrent is persisting. From them it drives four controls: the output enable, a current-limit request, a foldback request and a ramp-hold request. The thresholds, the filtering of the flags and the analog limiting itself belong to other blocks.

Each fault class has its own policy. Overvoltage and thermal shutdown switch the output off at once and keep it off. Thermal wins whenever it comes together with overcurrent. Overcurrent starts a protect phase with current limiting and moves to foldback if the persistence flag rises. After a programmed delay the supervisor tries nominal operation again. Once a programmed number of attempts is spent, the next overcurrent switches the output off for good. Undervoltage holds the ramp for the same delay and then retries without spending attempts. A host clear pulse releases the off state, but only while no fault flag is active. The attempt count starts again from zero after the output has run clean for a programmed qualification interval.

Delays and intervals are counted in ticks of an external millisecond enable.

Top module: `frs_supervisor`

## Requirements
- R1: In reset and in the first cycle after reset the supervisor is in normal operation: enable high; current limit, foldback and ramp hold all low.
- R2: An overcurrent flag seen in normal operation, with attempts left, enters protect at the next clock edge. In protect, enable and current limit are high and ramp hold is low.
- R3: An undervoltage flag seen in normal operation enters protect with ramp hold high and current limit low. Leaving an undervoltage protect phase does not use up an overcurrent attempt.
- R4: While in protect, a high persistence flag sets foldback from the next edge. Foldback then stays high until protect is left and is never high outside protect.
- R5: Protect lasts exactly cfg_delay+1 cycles while tick_ms is high on every cycle. Its timer advances only on cycles with tick_ms high. On leaving protect the supervisor returns to normal operation with all three requests low.
- R6: Each exit from an overcurrent protect phase uses one attempt. When every attempt is used, an overcurrent flag in normal operation gives the off state at the next edge: enable, current limit, foldback and ramp hold all low.
- R7: The number of attempts is cfg_retries clamped to the range 3 to 5. A value of 1 behaves as 3, and a value of 7 behaves as 5.
- R8: An overvoltage or thermal flag gives the off state at the next edge, from normal operation or from protect. When thermal and overcurrent come together, the result is the off state and not protect.
- R9: The off state is left only at an edge where host_clr is high and no fault flag is high. The supervisor then returns to normal operation with the attempt count at zero. host_clr has no effect in any other state.
- R10: The attempt count returns to zero once the output has spent more than cfg_qual ticks in normal operation with no fault flag. A shorter clean spell keeps the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | Millisecond enable that advances the delay and qualification timers |
| flt_uv | input | 1 | Qualified undervoltage fault |
| flt_ov | input | 1 | Qualified overvoltage fault |
| flt_oc | input | 1 | Qualified overcurrent fault |
| flt_th | input | 1 | Qualified thermal shutdown |
| oc_persist | input | 1 | Fault persists during protect; requests foldback |
| host_clr | input | 1 | Host clear pulse for the off state |
| cfg_delay | input | 16 | Retry delay in ticks |
| cfg_qual | input | 16 | Clean-run qualification interval in ticks |
| cfg_retries | input | 3 | Requested number of overcurrent attempts (clamped 3..5) |
| out_en | output | 1 | Output enable |
| out_lim | output | 1 | Current-limit request |
| out_fold | output | 1 | Foldback request |
| out_hold | output | 1 | Ramp-hold request |

## Verification
All four outputs decode the registered state, so every response is due one clock edge after the fault or clear that causes it. The exceptions are a protect phase, which ends cfg_delay+1 edges after entry when tick_ms is high, and the qualification clear, which takes effect only after cfg_qual+1 clean ticks. The bench drives inputs on the falling edge and samples on the falling edge after each rising edge, so each check sees the state one edge after its stimulus. Delay and qualification checks count whole edges from a known entry point, with one probe placed one edge before and one edge after each boundary.

// File: rtl/frs_pkg.sv
package frs_pkg;

   typedef enum logic [1:0] {
      ST_NORM  = 2'd0,
      ST_PROT  = 2'd1,
      ST_LATCH = 2'd2
   } frs_state_e;

   typedef enum logic [2:0] {
      CL_NONE = 3'd0,
      CL_UV   = 3'd1,
      CL_OC   = 3'd2,
      CL_OV   = 3'd3,
      CL_TH   = 3'd4
   } frs_class_e;

endpackage

// File: rtl/frs_fault_prio.sv
// Ranks simultaneous fault flags: thermal, then overvoltage, then
// overcurrent, then undervoltage.
module frs_fault_prio
   import frs_pkg::*;
(
   input  logic       flt_uv,
   input  logic       flt_ov,
   input  logic       flt_oc,
   input  logic       flt_th,
   output frs_class_e top_cls,
   output logic       any_flt
);

   always_comb begin
      if (flt_th)      top_cls = CL_TH;
      else if (flt_ov) top_cls = CL_OV;
      else if (flt_oc) top_cls = CL_OC;
      else if (flt_uv) top_cls = CL_UV;
      else             top_cls = CL_NONE;
   end

   assign any_flt = flt_uv | flt_ov | flt_oc | flt_th;

endmodule

// File: rtl/frs_tick_timer.sv
// Saturating up-counter; done while the count has reached the limit.
module frs_tick_timer #(
   parameter int unsigned W          = 16,
   parameter bit          TICK_GATED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic         done
);

   if (W < 2) begin : g_w_bad
      $error("frs_tick_timer: W must be at least 2");
   end

   logic [W-1:0] cnt_q;
   logic         adv;

   if (TICK_GATED) begin : g_gated
      assign adv = tick;
   end else begin : g_free
      assign adv = 1'b1;
   end

   assign done = (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr)            cnt_q <= '0;
      else if (adv && !done)   cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/frs_retry_count.sv
// Attempt counter with a clamped programmable ceiling.
module frs_retry_count #(
   parameter int unsigned W     = 3,
   parameter int unsigned N_MIN = 3,
   parameter int unsigned N_MAX = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   input  logic [W-1:0] cfg_max,
   output logic [W-1:0] cnt,
   output logic         exhausted
);

   localparam logic [W-1:0] LO = W'(N_MIN);
   localparam logic [W-1:0] HI = W'(N_MAX);

   if (N_MIN > N_MAX) begin : g_order_bad
      $error("frs_retry_count: N_MIN exceeds N_MAX");
   end
   if (N_MAX >= (1 << W)) begin : g_width_bad
      $error("frs_retry_count: N_MAX does not fit in W bits");
   end

   logic [W-1:0] eff_max;
   logic [W-1:0] cnt_q;

   if (N_MIN == N_MAX) begin : g_fixed
      assign eff_max = LO;
   end else begin : g_clamp
      assign eff_max = (cfg_max < LO) ? LO :
                       (cfg_max > HI) ? HI : cfg_max;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (clr)                 cnt_q <= '0;
      else if (inc && cnt_q != HI)  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt       = cnt_q;
   assign exhausted = (cnt_q >= eff_max);

endmodule

// File: rtl/frs_supervisor.sv
module frs_supervisor
   import frs_pkg::*;
#(
   parameter int unsigned DLY_W     = 16,
   parameter int unsigned QUAL_W    = 16,
   parameter int unsigned RETRY_W   = 3,
   parameter int unsigned RETRY_MIN = 3,
   parameter int unsigned RETRY_MAX = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_ms,
   input  logic               flt_uv,
   input  logic               flt_ov,
   input  logic               flt_oc,
   input  logic               flt_th,
   input  logic               oc_persist,
   input  logic               host_clr,
   input  logic [DLY_W-1:0]   cfg_delay,
   input  logic [QUAL_W-1:0]  cfg_qual,
   input  logic [RETRY_W-1:0] cfg_retries,
   output logic               out_en,
   output logic               out_lim,
   output logic               out_fold,
   output logic               out_hold
);

   frs_state_e         st_q, st_d;
   frs_class_e         cls_q, cls_d;
   frs_class_e         top_cls;
   logic               fold_q, fold_d;
   logic               any_flt;
   logic               dly_done, qual_done;
   logic               rc_inc, rc_clr, rc_full;
   logic [RETRY_W-1:0] rc_cnt;

   frs_fault_prio u_prio (
      .flt_uv  (flt_uv),
      .flt_ov  (flt_ov),
      .flt_oc  (flt_oc),
      .flt_th  (flt_th),
      .top_cls (top_cls),
      .any_flt (any_flt)
   );

   frs_tick_timer #(.W(DLY_W), .TICK_GATED(1'b1)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_q != ST_PROT),
      .tick  (tick_ms),
      .limit (cfg_delay),
      .done  (dly_done)
   );

   frs_tick_timer #(.W(QUAL_W), .TICK_GATED(1'b1)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   ((st_q != ST_NORM) || any_flt),
      .tick  (tick_ms),
      .limit (cfg_qual),
      .done  (qual_done)
   );

   frs_retry_count #(.W(RETRY_W), .N_MIN(RETRY_MIN), .N_MAX(RETRY_MAX)) u_rc (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc       (rc_inc),
      .clr       (rc_clr),
      .cfg_max   (cfg_retries),
      .cnt       (rc_cnt),
      .exhausted (rc_full)
   );

   always_comb begin
      st_d   = st_q;
      cls_d  = cls_q;
      fold_d = fold_q;
      rc_inc = 1'b0;
      rc_clr = 1'b0;
      unique case (st_q)
         ST_NORM: begin
            fold_d = 1'b0;
            unique case (top_cls)
               CL_TH, CL_OV: st_d = ST_LATCH;
               CL_OC: begin
                  if (rc_full) begin
                     st_d = ST_LATCH;
                  end else begin
                     st_d  = ST_PROT;
                     cls_d = CL_OC;
                  end
               end
               CL_UV: begin
                  st_d  = ST_PROT;
                  cls_d = CL_UV;
               end
               default: rc_clr = qual_done;
            endcase
         end
         ST_PROT: begin
            if (top_cls == CL_TH || top_cls == CL_OV) begin
               st_d   = ST_LATCH;
               fold_d = 1'b0;
            end else if (dly_done) begin
               st_d   = ST_NORM;
               fold_d = 1'b0;
               rc_inc = (cls_q == CL_OC);
            end else if (oc_persist) begin
               fold_d = 1'b1;
            end
         end
         ST_LATCH: begin
            fold_d = 1'b0;
            if (host_clr && !any_flt) begin
               st_d   = ST_NORM;
               rc_clr = 1'b1;
            end
         end
         default: begin
            st_d   = ST_LATCH;
            fold_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_NORM;
         cls_q  <= CL_NONE;
         fold_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         cls_q  <= cls_d;
         fold_q <= fold_d;
      end
   end

   assign out_en   = (st_q != ST_LATCH);
   assign out_lim  = (st_q == ST_PROT) && (cls_q == CL_OC);
   assign out_hold = (st_q == ST_PROT) && (cls_q == CL_UV);
   assign out_fold = (st_q == ST_PROT) && fold_q;

endmodule

// File: rtl/frs_supervisor_chk.sv
module frs_supervisor_chk #(
   parameter int unsigned RETRY_W   = 3,
   parameter int unsigned RETRY_MAX = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               flt_uv,
   input logic               flt_ov,
   input logic               flt_oc,
   input logic               flt_th,
   input logic               host_clr,
   input logic               out_en,
   input logic               out_lim,
   input logic               out_fold,
   input logic               out_hold,
   input logic [RETRY_W-1:0] rc_cnt
);

   localparam logic [RETRY_W-1:0] CAP = RETRY_W'(RETRY_MAX);

   logic any_in;
   assign any_in = flt_uv | flt_ov | flt_oc | flt_th;

   // R8
   fatal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_ov || flt_th) |=> !out_en);

   // R9
   off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_en && !(host_clr && !any_in)) |=> !out_en);

   // R9
   off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_en && host_clr && !any_in) |=> out_en);

   // R2
   lim_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_lim |-> (out_en && !out_hold));

   // R4
   fold_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_fold |-> (out_lim || out_hold));

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rc_cnt <= CAP);

endmodule

bind frs_supervisor frs_supervisor_chk #(
   .RETRY_W   (RETRY_W),
   .RETRY_MAX (RETRY_MAX)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .flt_uv   (flt_uv),
   .flt_ov   (flt_ov),
   .flt_oc   (flt_oc),
   .flt_th   (flt_th),
   .host_clr (host_clr),
   .out_en   (out_en),
   .out_lim  (out_lim),
   .out_fold (out_fold),
   .out_hold (out_hold),
   .rc_cnt   (rc_cnt)
);

// File: tb/sim_frs_supervisor.sv
module sim_frs_supervisor;

   localparam int CLK_PER = 10;
   localparam int NVEC    = 19;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick_ms;
   logic        flt_uv, flt_ov, flt_oc, flt_th, oc_persist, host_clr;
   logic [15:0] cfg_delay, cfg_qual;
   logic [2:0]  cfg_retries;
   logic        out_en, out_lim, out_fold, out_hold;

   int n_chk  = 0;
   int n_err  = 0;
   bit closed = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   frs_supervisor u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_ms     (tick_ms),
      .flt_uv      (flt_uv),
      .flt_ov      (flt_ov),
      .flt_oc      (flt_oc),
      .flt_th      (flt_th),
      .oc_persist  (oc_persist),
      .host_clr    (host_clr),
      .cfg_delay   (cfg_delay),
      .cfg_qual    (cfg_qual),
      .cfg_retries (cfg_retries),
      .out_en      (out_en),
      .out_lim     (out_lim),
      .out_fold    (out_fold),
      .out_hold    (out_hold)
   );

   // inputs {uv,ov,oc,th,persist,clr} , expected {en,lim,fold,hold}
   // delay 2, long qualification, tick high
   localparam logic [9:0] VEC [NVEC] = '{
      10'b000000_1000, 10'b001000_1100, 10'b001000_1100, 10'b001010_1110,
      10'b000000_1000, 10'b100000_1001, 10'b100010_1011, 10'b000000_1011,
      10'b000000_1000, 10'b010000_0000, 10'b000000_0000, 10'b001001_0000,
      10'b000001_1000, 10'b000100_0000, 10'b000101_0000, 10'b000001_1000,
      10'b001100_0000, 10'b000001_1000, 10'b000001_1000
   };
   localparam logic [23:0] TAGS [NVEC] = '{
      "R1 ", "R2 ", "R5 ", "R4 ", "R5 ", "R3 ", "R4 ", "R5 ", "R5 ", "R8 ",
      "R9 ", "R9 ", "R9 ", "R8 ", "R9 ", "R9 ", "R8 ", "R9 ", "R9 "
   };

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input logic [23:0] tag, input logic [3:0] exp);
      logic [3:0] act;
      act = {out_en, out_lim, out_fold, out_hold};
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: {en,lim,fold,hold} actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!closed) begin
         closed = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   task automatic idle_in();
      {flt_uv, flt_ov, flt_oc, flt_th, oc_persist, host_clr} = '0;
   endtask

   // force the off state and release it: attempt count back to zero
   task automatic zero_count();
      flt_ov = 1'b1; step();
      flt_ov = 1'b0; host_clr = 1'b1; step();
      host_clr = 1'b0;
   endtask

   // one overcurrent attempt with delay 2: protect lasts three edges
   task automatic oc_attempt(input logic [23:0] tag);
      flt_oc = 1'b1; step();
      chk(tag, 4'b1100);
      flt_oc = 1'b0;
      repeat (3) step();
      chk(tag, 4'b1000);
   endtask

   task automatic run_out(input logic [2:0] req, input int n, input logic [23:0] tag);
      zero_count();
      cfg_retries = req;
      for (int k = 0; k < n; k++) oc_attempt(tag);
      flt_oc = 1'b1; step();
      chk(tag, 4'b0000);
      flt_oc = 1'b0; host_clr = 1'b1; step();
      host_clr = 1'b0;
      chk("R9 ", 4'b1000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
   end

   initial begin
      rst_n = 1'b0; tick_ms = 1'b1; idle_in();
      cfg_delay = 16'd2; cfg_qual = 16'd1000; cfg_retries = 3'd3;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 ", 4'b1000);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         {flt_uv, flt_ov, flt_oc, flt_th, oc_persist, host_clr} = VEC[i][9:4];
         step();
         chk(TAGS[i], VEC[i][3:0]);
      end
      idle_in();

      // R6: three attempts then the off state
      run_out(3'd3, 3, "R6 ");
      // R7: clamp high and low
      run_out(3'd7, 5, "R7 ");
      run_out(3'd1, 3, "R7 ");

      // R3: undervoltage phases do not spend attempts
      zero_count();
      cfg_retries = 3'd3;
      for (int k = 0; k < 3; k++) oc_attempt("R6 ");
      flt_uv = 1'b1; step(); chk("R3 ", 4'b1001);
      flt_uv = 1'b0; repeat (3) step(); chk("R3 ", 4'b1000);
      flt_oc = 1'b1; step(); chk("R3 ", 4'b0000);
      flt_oc = 1'b0;

      // R10: clean run beyond the interval clears the count
      cfg_qual = 16'd4;
      zero_count();
      for (int k = 0; k < 3; k++) oc_attempt("R10");
      repeat (10) step();
      flt_oc = 1'b1; step(); chk("R10", 4'b1100);
      flt_oc = 1'b0; repeat (3) step();
      // R10: a spell of three clean ticks is too short
      zero_count();
      for (int k = 0; k < 3; k++) oc_attempt("R10");
      repeat (3) step();
      flt_oc = 1'b1; step(); chk("R10", 4'b0000);
      flt_oc = 1'b0; host_clr = 1'b1; step(); host_clr = 1'b0;
      chk("R9 ", 4'b1000);
      cfg_qual = 16'd1000;

      // R5: timer frozen without ticks
      zero_count();
      tick_ms = 1'b0;
      flt_oc = 1'b1; step(); flt_oc = 1'b0;
      repeat (20) step();
      chk("R5 ", 4'b1100);
      tick_ms = 1'b1;
      repeat (2) step(); chk("R5 ", 4'b1100);
      step();            chk("R5 ", 4'b1000);

      // R8: thermal during overcurrent protect, overvoltage during undervoltage protect
      flt_oc = 1'b1; step(); chk("R2 ", 4'b1100);
      flt_oc = 1'b0; flt_th = 1'b1; step(); chk("R8 ", 4'b0000);
      flt_th = 1'b0; host_clr = 1'b1; step(); host_clr = 1'b0; chk("R9 ", 4'b1000);
      flt_uv = 1'b1; step(); chk("R3 ", 4'b1001);
      flt_ov = 1'b1; step(); chk("R8 ", 4'b0000);
      idle_in(); step(); chk("R9 ", 4'b0000);

      // R1: reset releases the off state
      rst_n = 1'b0; step(); rst_n = 1'b1;
      chk("R1 ", 4'b1000);
      step(); chk("R1 ", 4'b1000);

      summary();
   end

endmodule